// File: doc/BRIEF.md
# Fracturable Integer Multiplier

This block is a hard multiplier that takes two 36-bit unsigned operands and returns a 72-bit result. It can work as one wide 36x36 multiplier. It can also split into two independent 18-bit halves, and each half can split again into two 9-bit lanes. The lanes run side by side and do not interact. The operand bits and the result bits each lane owns are fixed. Software-free configuration pins choose the arrangement for every operation, so a datapath can switch between one wide product and up to four narrow products from one cycle to the next.

Lane placement is direct. In any mode, a lane whose operand slice begins at bit `k` writes its product starting at result bit `2k`. In 18-bit mode the low half reads operand bits [17:0] and writes result bits [35:0]. The high half reads operand bits [35:18] and writes result bits [71:36].

A parameter adds an output register. With the register present, the result and its valid strobe appear one cycle after the operands are presented. The register loads only on valid cycles, so the last result stays visible between operations.

Top module: `fracmul36`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `res_valid` is 0 and `res_prod` is all zeros.
- R2: With `cfg_wide`=1, `res_prod` equals the full unsigned 72-bit product `opnd_a * opnd_b`.
- R3: With `cfg_wide`=0 and `cfg_nine[0]`=0, `res_prod[35:0]` equals `opnd_a[17:0] * opnd_b[17:0]`.
- R4: With `cfg_wide`=0 and `cfg_nine[1]`=0, `res_prod[71:36]` equals `opnd_a[35:18] * opnd_b[35:18]`.
- R5: With `cfg_wide`=0 and `cfg_nine[0]`=1, `res_prod[17:0]` equals `opnd_a[8:0] * opnd_b[8:0]`, and `res_prod[35:18]` equals `opnd_a[17:9] * opnd_b[17:9]`.
- R6: With `cfg_wide`=0 and `cfg_nine[1]`=1, `res_prod[53:36]` equals `opnd_a[26:18] * opnd_b[26:18]`, and `res_prod[71:54]` equals `opnd_a[35:27] * opnd_b[35:27]`.
- R7: The two halves choose their modes independently. With `cfg_nine` set to 01 or 10, each half follows R3/R5 or R4/R6 according to its own bit only.
- R8: With `cfg_wide`=1, the value of `cfg_nine` has no effect on `res_prod`.
- R9: All lanes treat operands as unsigned. All-ones operands give the largest positive product of each lane width, for example 0x1FF*0x1FF = 0x3FC01 in a 9-bit lane.
- R10: With the output register enabled (the default), `res_valid` in a cycle equals `in_valid` of the previous cycle. The result of R2 to R7 appears in the cycle after the operands are presented.
- R11: After a cycle with `in_valid`=0, `res_prod` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands and configuration are valid this cycle |
| cfg_wide | input | 1 | 1 selects one 36x36 multiply |
| cfg_nine | input | 2 | Per half, 1 selects two 9x9 lanes (bit 0 low half, bit 1 high half) |
| opnd_a | input | 36 | Operand A |
| opnd_b | input | 36 | Operand B |
| res_valid | output | 1 | Result valid |
| res_prod | output | 72 | Product bus |

## Verification
The bench targets lane crossover. If a slice is off by one bit or a lane writes the wrong result window, the error shows up only when neighbouring lanes carry different data. For that reason every mode combination is driven with all-ones, alternating and random operands. All-ones operands show whether the block treats operands as signed or drops a carry, because they give the largest product in every lane. The bench drives mixed configurations with `cfg_nine` bits set while `cfg_wide` is high; this exposes a half that obeys the wrong configuration bit or a wide mode that lets the split bits leak in. Idle cycles between valid operations show whether the register reloads on invalid cycles or the valid strobe is misaligned by a cycle.

// File: rtl/fracmul_pkg.sv
`timescale 1ns/1ps
package fracmul_pkg;
   // Per-half operating arrangement
   typedef enum logic [1:0] {
      HM_JOINT = 2'd0,   // half is part of the wide multiply
      HM_WHOLE = 2'd1,   // half is one 18x18 multiply
      HM_PAIR  = 2'd2    // half is two 9x9 multiplies
   } half_mode_t;
endpackage

// File: rtl/fracmul_mode_dec.sv
`timescale 1ns/1ps
module fracmul_mode_dec #(
   parameter int HALVES = 2
) (
   input  logic                                  cfg_wide,
   input  logic [HALVES-1:0]                     cfg_nine,
   output fracmul_pkg::half_mode_t [HALVES-1:0]  mode_o
);
   import fracmul_pkg::*;

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      assign mode_o[h] = cfg_wide     ? HM_JOINT :
                         cfg_nine[h]  ? HM_PAIR  : HM_WHOLE;
   end
endmodule

// File: rtl/fracmul_half.sv
`timescale 1ns/1ps
module fracmul_half #(
   parameter int HW = 18
) (
   input  fracmul_pkg::half_mode_t  mode_i,
   input  logic [HW-1:0]            a_i,
   input  logic [HW-1:0]            b_i,
   output logic [2*HW-1:0]          res_o
);
   import fracmul_pkg::*;

   localparam int QW    = HW / 2;
   localparam int LANES = 2;

   if ((HW % 2) != 0) begin : g_bad_width
      $error("fracmul_half: HW must be even");
   end

   logic [2*HW-1:0] whole_p;
   logic [2*HW-1:0] pair_p;

   assign whole_p = {{HW{1'b0}}, a_i} * {{HW{1'b0}}, b_i};

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign pair_p[l*2*QW +: 2*QW] =
         {{QW{1'b0}}, a_i[l*QW +: QW]} * {{QW{1'b0}}, b_i[l*QW +: QW]};
   end

   assign res_o = (mode_i == HM_PAIR) ? pair_p : whole_p;
endmodule

// File: rtl/fracmul_out_stage.sv
`timescale 1ns/1ps
module fracmul_out_stage #(
   parameter int W   = 72,
   parameter bit REG = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          vld_i,
   input  logic [W-1:0]  dat_i,
   output logic          vld_o,
   output logic [W-1:0]  dat_o
);
   if (REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld_o <= 1'b0;
            dat_o <= '0;
         end else begin
            vld_o <= vld_i;
            if (vld_i) dat_o <= dat_i;
         end
      end
   end else begin : g_comb
      assign vld_o = vld_i;
      assign dat_o = dat_i;
   end
endmodule

// File: rtl/fracmul36.sv
`timescale 1ns/1ps
module fracmul36 #(
   parameter int A_W     = 36,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             cfg_wide,
   input  logic [1:0]       cfg_nine,
   input  logic [A_W-1:0]   opnd_a,
   input  logic [A_W-1:0]   opnd_b,
   output logic             res_valid,
   output logic [2*A_W-1:0] res_prod
);
   import fracmul_pkg::*;

   localparam int HALVES = 2;
   localparam int HW     = A_W / HALVES;
   localparam int P_W    = 2 * A_W;

   if ((A_W % 4) != 0 || A_W < 4) begin : g_bad_width
      $error("fracmul36: A_W must be a positive multiple of 4");
   end

   half_mode_t [HALVES-1:0] hmode;
   logic [P_W-1:0]          wide_p;
   logic [P_W-1:0]          split_p;
   logic [P_W-1:0]          comb_p;

   fracmul_mode_dec #(.HALVES(HALVES)) u_dec (
      .cfg_wide (cfg_wide),
      .cfg_nine (cfg_nine),
      .mode_o   (hmode)
   );

   assign wide_p = {{A_W{1'b0}}, opnd_a} * {{A_W{1'b0}}, opnd_b};

   for (genvar h = 0; h < HALVES; h++) begin : g_half
      fracmul_half #(.HW(HW)) u_half (
         .mode_i (hmode[h]),
         .a_i    (opnd_a[h*HW +: HW]),
         .b_i    (opnd_b[h*HW +: HW]),
         .res_o  (split_p[h*2*HW +: 2*HW])
      );
   end

   assign comb_p = cfg_wide ? wide_p : split_p;

   fracmul_out_stage #(.W(P_W), .REG(OUT_REG)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_valid),
      .dat_i (comb_p),
      .vld_o (res_valid),
      .dat_o (res_prod)
   );
endmodule

// File: rtl/fracmul36_chk.sv
`timescale 1ns/1ps
module fracmul36_chk #(
   parameter int A_W     = 36,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             cfg_wide,
   input logic [1:0]       cfg_nine,
   input logic [A_W-1:0]   opnd_a,
   input logic [A_W-1:0]   opnd_b,
   input logic             res_valid,
   input logic [2*A_W-1:0] res_prod
);
   localparam int HW = A_W / 2;
   localparam int QW = A_W / 4;

   // Expected result: a lane at operand offset k lands at result offset 2k
   logic [2*A_W-1:0] exp_c;
   always_comb begin
      exp_c = '0;
      if (cfg_wide) begin
         exp_c = {{A_W{1'b0}}, opnd_a} * {{A_W{1'b0}}, opnd_b};
      end else begin
         for (int h = 0; h < 2; h++) begin
            if (cfg_nine[h]) begin
               for (int l = 0; l < 2; l++) begin
                  exp_c[2*(h*HW + l*QW) +: 2*QW] =
                     {{QW{1'b0}}, opnd_a[h*HW + l*QW +: QW]} *
                     {{QW{1'b0}}, opnd_b[h*HW + l*QW +: QW]};
               end
            end else begin
               exp_c[2*h*HW +: 2*HW] =
                  {{HW{1'b0}}, opnd_a[h*HW +: HW]} * {{HW{1'b0}}, opnd_b[h*HW +: HW]};
            end
         end
      end
   end

   if (OUT_REG) begin : g_seq
      p_reset_clear_r1: assert property (@(posedge clk)
         !rst_n |=> (!res_valid && res_prod == '0));

      p_valid_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         in_valid |=> res_valid);

      p_idle_lat_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> !res_valid);

      // R2 and R8: wide product regardless of the split bits
      p_wide_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && cfg_wide) |=> res_prod == $past(exp_c));

      // R3, R5, R7: low half follows its own split bit
      p_low_half_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !cfg_wide) |=> res_prod[2*HW-1:0] == $past(exp_c[2*HW-1:0]));

      // R4, R6, R7: high half follows its own split bit
      p_high_half_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (in_valid && !cfg_wide) |=> res_prod[4*HW-1:2*HW] == $past(exp_c[4*HW-1:2*HW]));

      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !in_valid |=> $stable(res_prod));
   end else begin : g_comb
      always_comb begin
         if (rst_n && in_valid) begin
            a_comb_prod_r2: assert (res_prod == exp_c);
         end
         a_comb_valid_r10: assert (res_valid == in_valid);
      end
   end
endmodule

bind fracmul36 fracmul36_chk #(.A_W(A_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .cfg_wide  (cfg_wide),
   .cfg_nine  (cfg_nine),
   .opnd_a    (opnd_a),
   .opnd_b    (opnd_b),
   .res_valid (res_valid),
   .res_prod  (res_prod)
);

// File: tb/sim_fracmul36.sv
`timescale 1ns/1ps
module sim_fracmul36;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        cfg_wide = 1'b0;
   logic [1:0]  cfg_nine = 2'b00;
   logic [35:0] opnd_a = '0;
   logic [35:0] opnd_b = '0;
   logic        res_valid;
   logic [71:0] res_prod;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   fracmul36 u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .cfg_wide  (cfg_wide),
      .cfg_nine  (cfg_nine),
      .opnd_a    (opnd_a),
      .opnd_b    (opnd_b),
      .res_valid (res_valid),
      .res_prod  (res_prod)
   );

   // Behavioural reference built from shifts and masks
   function automatic logic [71:0] ref_prod(input bit wide, input logic [1:0] nine,
                                            input logic [35:0] a, input logic [35:0] b);
      logic [71:0] r, x, y;
      r = '0;
      if (wide) begin
         x = {36'd0, a};
         y = {36'd0, b};
         return x * y;
      end
      for (int h = 0; h < 2; h++) begin
         if (nine[h]) begin
            for (int l = 0; l < 2; l++) begin
               x = ({36'd0, a} >> (18*h + 9*l)) & 72'h1FF;
               y = ({36'd0, b} >> (18*h + 9*l)) & 72'h1FF;
               r = r | ((x * y) << (36*h + 18*l));
            end
         end else begin
            x = ({36'd0, a} >> (18*h)) & 72'h3FFFF;
            y = ({36'd0, b} >> (18*h)) & 72'h3FFFF;
            r = r | ((x * y) << (36*h));
         end
      end
      return r;
   endfunction

   // Cycle model: state after each rising edge
   logic [71:0] m_prod  = '0;
   logic        m_valid = 1'b0;
   string       lo_tag  = "R1";
   string       hi_tag  = "R1";
   string       v_tag   = "R1";

   always @(posedge clk) begin
      if (!rst_n) begin
         m_prod  = '0;
         m_valid = 1'b0;
         lo_tag  = "R1";
         hi_tag  = "R1";
         v_tag   = "R1";
      end else begin
         m_valid = in_valid;
         v_tag   = "R10";
         if (in_valid) begin
            m_prod = ref_prod(cfg_wide, cfg_nine, opnd_a, opnd_b);
            if (&opnd_a && &opnd_b) begin
               lo_tag = "R9"; hi_tag = "R9";
            end else if (cfg_wide) begin
               lo_tag = (cfg_nine != 2'b00) ? "R8" : "R2";
               hi_tag = lo_tag;
            end else if (cfg_nine[0] != cfg_nine[1]) begin
               lo_tag = "R7"; hi_tag = "R7";
            end else begin
               lo_tag = cfg_nine[0] ? "R5" : "R3";
               hi_tag = cfg_nine[1] ? "R6" : "R4";
            end
         end else begin
            lo_tag = "R11"; hi_tag = "R11";
         end
      end
   end

   task automatic compare();
      n_chk++;
      if (res_valid !== m_valid) begin
         n_err++;
         $display("FAIL %s valid: actual=%0b expected=%0b", v_tag, res_valid, m_valid);
      end
      n_chk++;
      if (res_prod[35:0] !== m_prod[35:0]) begin
         n_err++;
         $display("FAIL %s low half: actual=%h expected=%h", lo_tag, res_prod[35:0], m_prod[35:0]);
      end
      n_chk++;
      if (res_prod[71:36] !== m_prod[71:36]) begin
         n_err++;
         $display("FAIL %s high half: actual=%h expected=%h", hi_tag, res_prod[71:36], m_prod[71:36]);
      end
   endtask

   task automatic step(input bit v, input bit w, input logic [1:0] n,
                       input logic [35:0] a, input logic [35:0] b);
      @(negedge clk);
      compare();
      in_valid = v;
      cfg_wide = w;
      cfg_nine = n;
      opnd_a   = a;
      opnd_b   = b;
   endtask

   function automatic logic [35:0] rnd36();
      logic [63:0] t;
      t = {$urandom(), $urandom()};
      return t[35:0];
   endfunction

   initial begin
      // R1: reset state
      repeat (3) begin
         @(negedge clk);
         compare();
      end
      rst_n = 1'b1;
      // Directed: every configuration with characteristic operands
      for (int c = 0; c < 8; c++) begin
         step(1'b1, c[2], c[1:0], 36'hF_FFFF_FFFF, 36'hF_FFFF_FFFF);  // R9
         step(1'b1, c[2], c[1:0], 36'hA_AAAA_AAAA, 36'h5_5555_5555);
         step(1'b1, c[2], c[1:0], 36'h1_FF00_01FF, 36'h0_01FF_FE01);
         step(1'b0, c[2], c[1:0], rnd36(), rnd36());                  // R11 idle
         step(1'b1, c[2], c[1:0], rnd36(), rnd36());
         step(1'b0, ~c[2], ~c[1:0], 36'h0, 36'h0);                    // R11 idle
         step(1'b0, c[2], c[1:0], 36'h0, 36'h0);
      end
      // Random mix of configurations and idle cycles
      for (int i = 0; i < 600; i++) begin
         logic [31:0] r;
         r = $urandom();
         step(r[0] | r[1], r[2], r[4:3], rnd36(), rnd36());
      end
      step(1'b0, 1'b0, 2'b00, 36'h0, 36'h0);
      step(1'b0, 1'b0, 2'b00, 36'h0, 36'h0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL R10 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule